// File: doc/BRIEF.md
# Strap-Configured Memory Window Decoder

This block decides, for every bus transfer, whether the address latched during the address phase belongs to the on-board memory array. It also produces the row number and the word position inside that row for the array controller. The window is configured by static straps. A five-bit start code places the window on any 64K-word boundary. A size code chooses a window of 2, 4 or 8 rows of 64K words. A mode strap selects either the full 22-bit byte address space or the narrow 18-bit one. An option strap returns the lower half of the I/O page to memory.

The address input is the word address, which is the byte address without its lane bit 0. Word bits 20..16 therefore carry byte address bits 21..17. The row and offset outputs follow the address combinationally. The select output is registered: it is captured on the first clock edge that sees the address strobe high, held while the strobe stays high, and dropped once the strobe is released.

Top module: `qram_window_decoder`

## Requirements
- R1: In wide mode, the select is set exactly when word-address bits 20..16, read as a block number, lie in the range from the start code up to start code + rows − 1.
- R2: Size code 2'b00 gives 2 rows, 2'b01 gives 4 rows and 2'b11 gives 8 rows. The unused code 2'b10 is treated as 2 rows.
- R3: When narrow mode is high, word-address bits 20..17 and start-code bits 4..1 are treated as zero. The rest of the window rule is unchanged.
- R4: A window that runs past the top of the active space (block 31 in wide mode, block 1 in narrow mode) does not wrap to the blocks at the bottom of that space.
- R5: A capture with the I/O-page strobe high never selects memory when the half-page option is low.
- R6: With the half-page option high, a capture with the I/O-page strobe high selects memory only if word-address bit 10 is 0 and the address is inside the window. If bit 10 is 1, it does not select.
- R7: The row index equals the block number minus the start code (after R3 masking), as 3 bits. The word offset equals word-address bits 15..0.
- R8: The select is computed on the clock edge where the strobe is first seen high and is visible after that edge. It holds while the strobe stays high, even if other inputs change. It is low after the first edge that sees the strobe low.
- R9: While reset is asserted, the select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| as_strobe | input | 1 | Address strobe; rising sample captures the decision |
| addr_i | input | 21 | Latched word address (byte address bits 21..1) |
| io_sel | input | 1 | I/O-page select strobe |
| start_strap | input | 5 | Window start block (64K-word units) |
| narrow_mode | input | 1 | 1 = 18-bit address space |
| size_code | input | 2 | Window size code |
| half_io | input | 1 | 1 = only the upper 2K of the I/O page is reserved |
| mem_sel | output | 1 | Registered memory select |
| row_idx | output | 3 | Row of the array addressed |
| word_ofs | output | 16 | Word position inside the row |

## Verification
The bench sweeps every block number against every start code, for all four size codes and both address modes, and compares the select and the row index with an arithmetic model. This sweep catches a window edge that is off by one row. It also catches a subtraction that wraps the window past the top of the space back to block 0, and a narrow mode that leaves the high address lines or start bits live. A separate sweep runs I/O-page cycles with the half-page option on and off and both values of bit 10. A gate that tested the wrong bit, or ignored the option, would then select inside the reserved page. Timing checks change the address while the strobe is held high, which exposes a select that re-evaluates instead of holding. They also release the strobe, which exposes a select that never drops.

// File: rtl/qwin_pkg.sv
package qwin_pkg;

    localparam int unsigned ROW_IDX_W = 3;

    typedef struct packed {
        logic sel;
        logic strobe_prev;
    } qwin_state_t;

    // log2 of the row count selected by the size straps
    function automatic logic [1:0] rows_log2(input logic [1:0] code);
        logic [1:0] lg;
        case (code)
            2'b01:   lg = 2'd2;
            2'b11:   lg = 2'd3;
            default: lg = 2'd1;
        endcase
        return lg;
    endfunction

endpackage

// File: rtl/qwin_addr_norm.sv
module qwin_addr_norm #(
    parameter int unsigned WADDR_W  = 21,
    parameter int unsigned NARROW_W = 17,
    parameter int unsigned ROW_LSB  = 16,
    localparam int unsigned BLK_W   = WADDR_W - ROW_LSB
) (
    input  logic [WADDR_W-1:0] addr_i,
    input  logic [BLK_W-1:0]   start_i,
    input  logic               narrow_i,
    output logic [BLK_W-1:0]   blk_o,
    output logic [BLK_W-1:0]   start_o,
    output logic [ROW_LSB-1:0] ofs_o
);

    logic [WADDR_W-1:0] eff_addr;

    genvar gi;
    generate
        for (gi = 0; gi < WADDR_W; gi++) begin : g_addr_mask
            if (gi >= NARROW_W) begin : g_hi
                assign eff_addr[gi] = addr_i[gi] & ~narrow_i;
            end else begin : g_lo
                assign eff_addr[gi] = addr_i[gi];
            end
        end
        for (gi = 0; gi < BLK_W; gi++) begin : g_start_mask
            if (gi + ROW_LSB >= NARROW_W) begin : g_hi
                assign start_o[gi] = start_i[gi] & ~narrow_i;
            end else begin : g_lo
                assign start_o[gi] = start_i[gi];
            end
        end
    endgenerate

    assign blk_o = eff_addr[WADDR_W-1:ROW_LSB];
    assign ofs_o = eff_addr[ROW_LSB-1:0];

endmodule

// File: rtl/qwin_window.sv
module qwin_window
    import qwin_pkg::*;
#(
    parameter int unsigned BLK_W = 5
) (
    input  logic [BLK_W-1:0]     blk_i,
    input  logic [BLK_W-1:0]     start_i,
    input  logic [1:0]           size_code_i,
    output logic                 hit_o,
    output logic [ROW_IDX_W-1:0] row_o
);

    logic [BLK_W:0]   diff;
    logic [BLK_W-1:0] rows;

    always_comb begin
        rows  = BLK_W'(1) << rows_log2(size_code_i);
        // extra bit flags a block below the start; no modulo wrap
        diff  = {1'b0, blk_i} - {1'b0, start_i};
        hit_o = !diff[BLK_W] && (diff[BLK_W-1:0] < rows);
        row_o = diff[ROW_IDX_W-1:0];
    end

endmodule

// File: rtl/qwin_io_gate.sv
module qwin_io_gate (
    input  logic io_sel_i,
    input  logic half_i,
    input  logic lower_half_i,
    input  logic hit_i,
    output logic sel_o
);

    logic allow;

    always_comb begin
        allow = !io_sel_i || (half_i && lower_half_i);
        sel_o = hit_i && allow;
    end

endmodule

// File: rtl/qram_window_decoder.sv
module qram_window_decoder
    import qwin_pkg::*;
#(
    parameter int unsigned WADDR_W  = 21,
    parameter int unsigned NARROW_W = 17,
    parameter int unsigned ROW_LSB  = 16,
    parameter int unsigned HALF_BIT = 10,
    localparam int unsigned BLK_W   = WADDR_W - ROW_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 as_strobe,
    input  logic [WADDR_W-1:0]   addr_i,
    input  logic                 io_sel,
    input  logic [BLK_W-1:0]     start_strap,
    input  logic                 narrow_mode,
    input  logic [1:0]           size_code,
    input  logic                 half_io,
    output logic                 mem_sel,
    output logic [ROW_IDX_W-1:0] row_idx,
    output logic [ROW_LSB-1:0]   word_ofs
);

    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] eff_start;
    logic             win_hit;
    logic             sel_now;
    qwin_state_t      st_d;
    qwin_state_t      st_q;

    qwin_addr_norm #(
        .WADDR_W (WADDR_W),
        .NARROW_W(NARROW_W),
        .ROW_LSB (ROW_LSB)
    ) i_norm (
        .addr_i  (addr_i),
        .start_i (start_strap),
        .narrow_i(narrow_mode),
        .blk_o   (blk),
        .start_o (eff_start),
        .ofs_o   (word_ofs)
    );

    qwin_window #(
        .BLK_W(BLK_W)
    ) i_window (
        .blk_i      (blk),
        .start_i    (eff_start),
        .size_code_i(size_code),
        .hit_o      (win_hit),
        .row_o      (row_idx)
    );

    qwin_io_gate i_gate (
        .io_sel_i    (io_sel),
        .half_i      (half_io),
        .lower_half_i(!addr_i[HALF_BIT]),
        .hit_i       (win_hit),
        .sel_o       (sel_now)
    );

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = as_strobe;
        if (!as_strobe) begin
            st_d.sel = 1'b0;
        end else if (!st_q.strobe_prev) begin
            st_d.sel = sel_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_sel = st_q.sel;

    // R8
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel) |-> $past(as_strobe));

    // R8
    sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_strobe |=> !mem_sel);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_strobe && st_q.strobe_prev) |=> $stable(mem_sel));

    // R5
    io_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_strobe && !st_q.strobe_prev && io_sel && !half_io) |=> !mem_sel);

    // R6
    io_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_strobe && !st_q.strobe_prev && io_sel && addr_i[HALF_BIT]) |=> !mem_sel);

endmodule

// File: tb/test_qram_window_decoder.sv
`timescale 1ns/1ps
module test_qram_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_strobe = 1'b0;
    logic [20:0] addr_i = '0;
    logic        io_sel = 1'b0;
    logic [4:0]  start_strap = '0;
    logic        narrow_mode = 1'b0;
    logic [1:0]  size_code = '0;
    logic        half_io = 1'b0;
    logic        mem_sel;
    logic [2:0]  row_idx;
    logic [15:0] word_ofs;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    qram_window_decoder i_qram_window_decoder (
        .clk(clk), .rst_n(rst_n), .as_strobe(as_strobe), .addr_i(addr_i),
        .io_sel(io_sel), .start_strap(start_strap), .narrow_mode(narrow_mode),
        .size_code(size_code), .half_io(half_io), .mem_sel(mem_sel),
        .row_idx(row_idx), .word_ofs(word_ofs)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nrows(input int sz);
        return (sz == 1) ? 4 : (sz == 3) ? 8 : 2;
    endfunction

    function automatic int eblk(input int b, input bit nar);
        return nar ? (b & 1) : b;
    endfunction

    function automatic bit exp_sel(input int b, input int s, input bit nar, input int sz,
                                   input bit io, input bit half, input bit b10);
        int eb = eblk(b, nar);
        int es = eblk(s, nar);
        bit win = (eb >= es) && (eb - es < nrows(sz));
        return win && (!io || (half && !b10));
    endfunction

    // one strobe capture; checks select, row and offset
    task automatic capture(input int b, input int s, input bit nar, input int sz,
                           input bit io, input bit half, input int low, input string tag);
        bit e;
        @(negedge clk);
        addr_i      = 21'((b << 16) | (low & 16'hffff));
        start_strap = 5'(s);
        narrow_mode = nar;
        size_code   = 2'(sz);
        io_sel      = io;
        half_io     = half;
        as_strobe   = 1'b1;
        e = exp_sel(b, s, nar, sz, io, half, low[10]);
        @(negedge clk);
        chk(mem_sel == e, tag, mem_sel, e);
        chk(word_ofs == 16'(low), "R7 offset", word_ofs, low & 16'hffff);
        if (e) chk(row_idx == 3'(eblk(b, nar) - eblk(s, nar)), "R7 row", row_idx,
                   eblk(b, nar) - eblk(s, nar));
        as_strobe = 1'b0;
        io_sel    = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        as_strobe = 1'b1;
        @(negedge clk);
        // R9: strobe high during reset leaves select low
        chk(mem_sel == 1'b0, "R9 reset", mem_sel, 0);
        as_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel == 1'b0, "R9 after reset", mem_sel, 0);

        // R1 R2 R3 R4 R7: full sweep of blocks, starts, sizes and modes
        for (int nar = 0; nar < 2; nar++)
            for (int sz = 0; sz < 4; sz++)
                for (int s = 0; s < 32; s++)
                    for (int b = 0; b < 32; b++)
                        capture(b, s, bit'(nar), sz, 1'b0, 1'b0,
                                (b * 977 + s * 131 + sz * 7) & 16'hffff,
                                nar ? "R3 sweep" : "R1 sweep");

        // R2: size boundaries, start 4
        capture(5, 4, 0, 0, 0, 0, 0, "R2 two rows in");
        capture(6, 4, 0, 0, 0, 0, 0, "R2 two rows out");
        capture(7, 4, 0, 1, 0, 0, 0, "R2 four rows in");
        capture(8, 4, 0, 1, 0, 0, 0, "R2 four rows out");
        capture(11, 4, 0, 3, 0, 0, 0, "R2 eight rows in");
        capture(12, 4, 0, 3, 0, 0, 0, "R2 eight rows out");
        capture(6, 4, 0, 2, 0, 0, 0, "R2 code 10 as two rows");
        // R4: no wrap past the top of the space
        capture(0, 30, 0, 3, 0, 0, 0, "R4 wide no wrap");
        capture(31, 30, 0, 3, 0, 0, 0, "R4 wide top block");
        capture(0, 1, 1, 3, 0, 0, 0, "R4 narrow no wrap");
        // R3: high lines ignored in narrow mode
        capture(17, 0, 1, 0, 0, 0, 0, "R3 aliased block");

        // R5 R6: I/O page cycles, window covers blocks 28..31
        for (int b = 24; b < 32; b++)
            for (int half = 0; half < 2; half++)
                for (int hb = 0; hb < 2; hb++)
                    capture(b, 28, 0, 3, 1'b1, bit'(half), (hb << 10) | 16'h03f0,
                            half ? "R6 half page" : "R5 io page");

        // R8: hold while strobe stays high, drop on release
        @(negedge clk);
        addr_i = 21'(2 << 16); start_strap = 0; narrow_mode = 0; size_code = 3;
        io_sel = 0; half_io = 0; as_strobe = 1'b1;
        @(negedge clk);
        chk(mem_sel == 1'b1, "R8 capture", mem_sel, 1);
        addr_i = 21'(20 << 16);
        @(negedge clk);
        chk(mem_sel == 1'b1, "R8 hold", mem_sel, 1);
        as_strobe = 1'b0;
        @(negedge clk);
        chk(mem_sel == 1'b0, "R8 drop", mem_sel, 0);
        as_strobe = 1'b1;
        @(negedge clk);
        chk(mem_sel == 1'b0, "R8 miss capture", mem_sel, 0);
        addr_i = 21'(3 << 16);
        @(negedge clk);
        chk(mem_sel == 1'b0, "R8 no late select", mem_sel, 0);
        as_strobe = 1'b0;
        @(negedge clk);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule